// File: doc/BRIEF.md
# Branch Target Buffer with Indirect Target Cache

This block sits at the fetch stage and supplies the next fetch address. Each cycle it takes the address about to be fetched and, in the same cycle, reports whether that address holds a branch known to be taken. If so, it reports the branch's kind and its predicted destination. If not, it reports the sequential successor. Only branches seen taken are kept, in a set-associative store of tags and destinations.

A branch whose stored kind is indirect can reach many destinations, so its destination comes from a second, tagless table. That table is indexed by the fetch address XORed with a short register of recent indirect destinations. The same branch can then predict different targets along different paths.

Branch resolution writes back through one update port, at most once per cycle. A taken resolution allocates or refreshes an entry. A not-taken resolution removes the entry. A taken indirect resolution also writes the path-indexed table and advances the path register. Lookups never change any state.

Top module: `btb_predictor`

## Requirements
- R1: After reset every entry is invalid, the path register is zero, and every lookup misses.
- R2: A taken resolution for an address with no entry allocates one. From the next cycle, a lookup of that address hits and returns the resolved destination and kind. Kind codes are 0 conditional, 1 jump, 2 call, 3 indirect.
- R3: On a miss, `lk_hit` is 0, `lk_type` is 0 and `lk_target` is the lookup address plus 4.
- R4: A taken resolution for an address already stored rewrites that entry's destination and kind in place. An address never occupies more than one way.
- R5: A not-taken resolution invalidates a matching entry. If there is no matching entry, it changes nothing.
- R6: Allocation picks the lowest-numbered invalid way of the set. If all ways are valid, it picks the way least recently written by a taken resolution. Lookups do not affect this order.
- R7: The set index is address bits [9:2] (256 sets of 4 ways). Addresses 1 KiB apart share a set and are told apart by the remaining upper bits.
- R8: On a hit of kind 3, the destination comes from the path-indexed table at index (address bits [9:2]) XOR path register, if that slot is valid. Otherwise it comes from the buffer entry.
- R9: A taken kind-3 resolution first writes its destination into the path-indexed table at the index formed with the path register's current value. It then shifts the path register left by 2 and fills the vacated low bits with destination bits [3:2]. No other resolution touches the table or the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_pc | input | 32 | Address being fetched |
| lk_hit | output | 1 | A taken branch is predicted at `lk_pc` |
| lk_target | output | 32 | Predicted next fetch address |
| lk_type | output | 2 | Kind of the hit branch, 0 on a miss |
| rs_valid | input | 1 | A resolved branch is presented this cycle |
| rs_pc | input | 32 | Address of the resolved branch |
| rs_taken | input | 1 | The resolved branch was taken |
| rs_target | input | 32 | Actual destination of the resolved branch |
| rs_type | input | 2 | Kind of the resolved branch |

## Verification
The hardest case to reach from the ports is an indirect hit that takes its destination from the path-indexed table while the buffer entry holds a different destination. Both structures are written by the same resolution, so they normally agree. The stimulus resolves one indirect branch twice, under two different path-register values, so the two table slots and the buffer end up holding different destinations. It then resolves a second indirect branch whose destinations shift zeros into the path register until the register returns to the first value. A lookup at that point must return the older destination. Replacement order is reached by filling one set, touching its oldest way with a resolution and looking up another way, so that only an order driven by resolutions alone gives the expected victim.

// File: rtl/btb_pkg.sv
// Shared definitions for the branch target buffer.
// Assumes 32-bit word-aligned fetch addresses.
package btb_pkg;

    // Kind code stored with each entry; value 3 selects the path-indexed table.
    typedef enum logic [1:0] {
        BR_COND = 2'd0,
        BR_JUMP = 2'd1,
        BR_CALL = 2'd2,
        BR_IND  = 2'd3
    } br_kind_e;

    localparam int ADDR_LSB = 2;  // word alignment: low address bits are not indexed

endpackage

// File: rtl/btb_way.sv
// One way of the target buffer: valid, tag, destination and kind per set.
// Offers a lookup read port, an update-side probe, and one write/clear port
// that acts on the probed set. Assumes write and clear are never both set.
module btb_way
    import btb_pkg::*;
#(
    parameter  int PC_W  = 32,
    parameter  int SETS  = 256,
    parameter  int TAG_W = 22,
    localparam int SET_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] lk_set,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic [PC_W-1:0]  lk_target,
    output br_kind_e         lk_kind,
    input  logic [SET_W-1:0] up_set,
    input  logic [TAG_W-1:0] up_tag,
    output logic             up_valid,
    output logic             up_hit,
    input  logic             wr_en,
    input  logic             clr_en,
    input  logic [PC_W-1:0]  wr_target,
    input  br_kind_e         wr_kind
);

    logic [SETS-1:0]  valid_q;
    logic [TAG_W-1:0] tag_q  [SETS];
    logic [PC_W-1:0]  tgt_q  [SETS];
    br_kind_e         kind_q [SETS];

    // Lookup compare for the fetch address.
    always_comb begin
        lk_hit    = valid_q[lk_set] && (tag_q[lk_set] == lk_tag);
        lk_target = tgt_q[lk_set];
        lk_kind   = kind_q[lk_set];
    end

    // Probe compare for the resolving branch.
    always_comb begin
        up_valid = valid_q[up_set];
        up_hit   = valid_q[up_set] && (tag_q[up_set] == up_tag);
    end

    // Valid bits: cleared by reset, set by allocation, cleared by a not-taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[up_set] <= 1'b1;
        end else if (clr_en) begin
            valid_q[up_set] <= 1'b0;
        end
    end

    // Payload store: written on allocation or refresh, no reset needed.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[up_set]  <= up_tag;
            tgt_q[up_set]  <= wr_target;
            kind_q[up_set] <= wr_kind;
        end
    end

endmodule

// File: rtl/btb_lru.sv
// Per-set recency order as one age per way (0 = newest, WAYS-1 = oldest).
// Picks a victim for the probed set and ages the set when a way is touched.
// Assumes WAYS is a power of two, at least 2.
module btb_lru #(
    parameter  int SETS  = 256,
    parameter  int WAYS  = 4,
    localparam int SET_W = $clog2(SETS),
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SET_W-1:0] set_i,
    input  logic [WAYS-1:0]  valid_i,
    output logic [WAY_W-1:0] victim_o,
    input  logic             touch_en,
    input  logic [WAY_W-1:0] touch_way
);

    logic [WAY_W-1:0] age_q [SETS][WAYS];
    logic [WAY_W-1:0] touch_age;

    // Victim choice: lowest invalid way first, otherwise the oldest way.
    always_comb begin
        logic found;
        found    = 1'b0;
        victim_o = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !valid_i[w]) begin
                victim_o = WAY_W'(w);
                found    = 1'b1;
            end
        end
        if (!found) begin
            for (int w = 0; w < WAYS; w++) begin
                if (age_q[set_i][w] == WAY_W'(WAYS - 1)) begin
                    victim_o = WAY_W'(w);
                end
            end
        end
    end

    // Current age of the way being touched.
    always_comb touch_age = age_q[set_i][touch_way];

    // Age update: touched way becomes newest, younger ways grow one older.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) begin
                for (int w = 0; w < WAYS; w++) begin
                    age_q[s][w] <= WAY_W'(w);
                end
            end
        end else if (touch_en) begin
            for (int w = 0; w < WAYS; w++) begin
                if (WAY_W'(w) == touch_way) begin
                    age_q[set_i][w] <= '0;
                end else if (age_q[set_i][w] < touch_age) begin
                    age_q[set_i][w] <= age_q[set_i][w] + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/btb_itc.sv
// Tagless indirect destination table indexed by address XOR path register.
// The path register collects SHIFT low bits of each taken indirect destination.
// Assumes SHIFT is smaller than the index width.
module btb_itc
    import btb_pkg::*;
#(
    parameter  int PC_W  = 32,
    parameter  int DEPTH = 256,
    parameter  int SHIFT = 2,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  lk_pc,
    output logic             lk_valid,
    output logic [PC_W-1:0]  lk_target,
    input  logic             wr_en,
    input  logic [PC_W-1:0]  wr_pc,
    input  logic [PC_W-1:0]  wr_target,
    output logic [IDX_W-1:0] hist_o
);

    logic [DEPTH-1:0] valid_q;
    logic [PC_W-1:0]  tgt_q [DEPTH];
    logic [IDX_W-1:0] hist_q;
    logic [IDX_W-1:0] lk_idx;
    logic [IDX_W-1:0] wr_idx;

    // Hashed indices for lookup and write, both using the current path.
    always_comb begin
        lk_idx = lk_pc[ADDR_LSB +: IDX_W] ^ hist_q;
        wr_idx = wr_pc[ADDR_LSB +: IDX_W] ^ hist_q;
    end

    // Lookup read of the hashed slot.
    always_comb begin
        lk_valid  = valid_q[lk_idx];
        lk_target = tgt_q[lk_idx];
    end

    assign hist_o = hist_q;

    // Valid bits and path register: reset clears, an indirect write advances.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            hist_q  <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
            hist_q <= (hist_q << SHIFT) | IDX_W'(wr_target[ADDR_LSB +: SHIFT]);
        end
    end

    // Destination store, overwritten with the resolved destination.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tgt_q[wr_idx] <= wr_target;
        end
    end

endmodule

// File: rtl/btb_predictor.sv
// Fetch-stage next-address predictor: set-associative store of taken
// branches plus a path-indexed table for indirect branches. The lookup is
// combinational on lk_pc; resolutions write at the clock edge.
// Assumes at most one resolution per cycle and word-aligned addresses.
module btb_predictor
    import btb_pkg::*;
#(
    parameter int PC_W       = 32,
    parameter int ENTRIES    = 1024,
    parameter int WAYS       = 4,
    parameter int ITC_DEPTH  = 256,
    parameter int HIST_SHIFT = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    output logic            lk_hit,
    output logic [PC_W-1:0] lk_target,
    output logic [1:0]      lk_type,
    input  logic            rs_valid,
    input  logic [PC_W-1:0] rs_pc,
    input  logic            rs_taken,
    input  logic [PC_W-1:0] rs_target,
    input  logic [1:0]      rs_type
);

    localparam int SETS   = ENTRIES / WAYS;
    localparam int SET_W  = $clog2(SETS);
    localparam int TAG_W  = PC_W - ADDR_LSB - SET_W;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int HIST_W = $clog2(ITC_DEPTH);

    logic [SET_W-1:0]  lk_set, up_set;
    logic [TAG_W-1:0]  lk_tag, up_tag;
    logic [WAYS-1:0]   way_hit, up_hit_vec, up_valid_vec, wr_way, clr_way;
    logic [PC_W-1:0]   way_tgt  [WAYS];
    br_kind_e          way_kind [WAYS];
    logic [PC_W-1:0]   btb_tgt;
    br_kind_e          btb_kind;
    logic [WAY_W-1:0]  up_hit_idx, victim, alloc_way;
    logic              up_any;
    logic              itc_valid;
    logic [PC_W-1:0]   itc_tgt;
    logic              itc_wr;
    logic [HIST_W-1:0] itc_hist;

    // Address split into set index and tag for both ports.
    always_comb begin
        lk_set = lk_pc[ADDR_LSB +: SET_W];
        lk_tag = lk_pc[PC_W-1 -: TAG_W];
        up_set = rs_pc[ADDR_LSB +: SET_W];
        up_tag = rs_pc[PC_W-1 -: TAG_W];
    end

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        btb_way #(
            .PC_W (PC_W),
            .SETS (SETS),
            .TAG_W(TAG_W)
        ) u_way (
            .clk      (clk),
            .rst_n    (rst_n),
            .lk_set   (lk_set),
            .lk_tag   (lk_tag),
            .lk_hit   (way_hit[g]),
            .lk_target(way_tgt[g]),
            .lk_kind  (way_kind[g]),
            .up_set   (up_set),
            .up_tag   (up_tag),
            .up_valid (up_valid_vec[g]),
            .up_hit   (up_hit_vec[g]),
            .wr_en    (wr_way[g]),
            .clr_en   (clr_way[g]),
            .wr_target(rs_target),
            .wr_kind  (br_kind_e'(rs_type))
        );
    end

    // Lookup way select: at most one way matches.
    always_comb begin
        btb_tgt  = '0;
        btb_kind = BR_COND;
        for (int w = 0; w < WAYS; w++) begin
            if (way_hit[w]) begin
                btb_tgt  = way_tgt[w];
                btb_kind = way_kind[w];
            end
        end
    end

    // Update-side match encode.
    always_comb begin
        up_any     = |up_hit_vec;
        up_hit_idx = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (up_hit_vec[w]) up_hit_idx = WAY_W'(w);
        end
    end

    btb_lru #(
        .SETS(SETS),
        .WAYS(WAYS)
    ) u_lru (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    (up_set),
        .valid_i  (up_valid_vec),
        .victim_o (victim),
        .touch_en (rs_valid && rs_taken),
        .touch_way(alloc_way)
    );

    // Way write enables: refresh the matching way, else fill the victim.
    always_comb begin
        alloc_way = up_any ? up_hit_idx : victim;
        for (int w = 0; w < WAYS; w++) begin
            wr_way[w]  = rs_valid && rs_taken && (alloc_way == WAY_W'(w));
            clr_way[w] = rs_valid && !rs_taken && up_hit_vec[w];
        end
        itc_wr = rs_valid && rs_taken && (br_kind_e'(rs_type) == BR_IND);
    end

    btb_itc #(
        .PC_W (PC_W),
        .DEPTH(ITC_DEPTH),
        .SHIFT(HIST_SHIFT)
    ) u_itc (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_pc    (lk_pc),
        .lk_valid (itc_valid),
        .lk_target(itc_tgt),
        .wr_en    (itc_wr),
        .wr_pc    (rs_pc),
        .wr_target(rs_target),
        .hist_o   (itc_hist)
    );

    // Output choice: fall-through, buffer destination, or path-indexed destination.
    always_comb begin
        lk_hit = |way_hit;
        if (!lk_hit) begin
            lk_target = lk_pc + PC_W'(4);
            lk_type   = 2'd0;
        end else begin
            lk_type   = btb_kind;
            lk_target = (btb_kind == BR_IND && itc_valid) ? itc_tgt : btb_tgt;
        end
    end

endmodule

// File: rtl/btb_predictor_chk.sv
// Property checker for btb_predictor, attached by the bind below.
// Observes the ports plus the way match vector and the path register.
module btb_predictor_chk #(
    parameter int PC_W   = 32,
    parameter int WAYS   = 4,
    parameter int HIST_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [PC_W-1:0]   lk_pc,
    input logic              lk_hit,
    input logic [PC_W-1:0]   lk_target,
    input logic [1:0]        lk_type,
    input logic              rs_valid,
    input logic [PC_W-1:0]   rs_pc,
    input logic              rs_taken,
    input logic [PC_W-1:0]   rs_target,
    input logic [1:0]        rs_type,
    input logic [WAYS-1:0]   way_hit,
    input logic [HIST_W-1:0] itc_hist
);

    AST_MISS_SEQUENTIAL: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_hit |-> (lk_target == lk_pc + PC_W'(4) && lk_type == 2'd0)); // R3

    AST_SINGLE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_hit)); // R4

    AST_TAKEN_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && rs_taken) |=> (lk_pc != $past(rs_pc) || lk_hit)); // R2

    AST_DIRECT_REFRESH: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && rs_taken && rs_type != 2'd3)
        |=> (lk_pc != $past(rs_pc) || (lk_target == $past(rs_target) && lk_type == $past(rs_type)))); // R4

    AST_NOT_TAKEN_GONE: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && !rs_taken) |=> (lk_pc != $past(rs_pc) || !lk_hit)); // R5

    AST_PATH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(rs_valid && rs_taken && rs_type == 2'd3) |=> $stable(itc_hist)); // R9

endmodule

bind btb_predictor btb_predictor_chk #(
    .PC_W  (PC_W),
    .WAYS  (WAYS),
    .HIST_W(HIST_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_pc    (lk_pc),
    .lk_hit   (lk_hit),
    .lk_target(lk_target),
    .lk_type  (lk_type),
    .rs_valid (rs_valid),
    .rs_pc    (rs_pc),
    .rs_taken (rs_taken),
    .rs_target(rs_target),
    .rs_type  (rs_type),
    .way_hit  (way_hit),
    .itc_hist (itc_hist)
);

// File: tb/btb_predictor_tb.sv
// Self-checking bench: a vector table for the buffer, then directed tests
// for the indirect path and reset.
module btb_predictor_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] lk_pc = '0;
    logic        lk_hit;
    logic [31:0] lk_target;
    logic [1:0]  lk_type;
    logic        rs_valid = 1'b0;
    logic [31:0] rs_pc = '0;
    logic        rs_taken = 1'b0;
    logic [31:0] rs_target = '0;
    logic [1:0]  rs_type = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    btb_predictor u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .lk_pc    (lk_pc),
        .lk_hit   (lk_hit),
        .lk_target(lk_target),
        .lk_type  (lk_type),
        .rs_valid (rs_valid),
        .rs_pc    (rs_pc),
        .rs_taken (rs_taken),
        .rs_target(rs_target),
        .rs_type  (rs_type)
    );

    typedef struct packed {
        logic        upd;
        logic [31:0] pc;
        logic        tk;
        logic [31:0] tgt;
        logic [1:0]  kd;
        logic        eh;
        logic [31:0] et;
        logic [1:0]  ek;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t TBL [NV] = '{
        '{1'b1, 32'h0004, 1'b1, 32'h0100, 2'd0, 1'b0, 32'h0,    2'd0, 4'd2}, // R2 allocate
        '{1'b0, 32'h0004, 1'b0, 32'h0,    2'd0, 1'b1, 32'h0100, 2'd0, 4'd2}, // R2 hit
        '{1'b0, 32'h0404, 1'b0, 32'h0,    2'd0, 1'b0, 32'h0408, 2'd0, 4'd7}, // R7 same set, other tag
        '{1'b1, 32'h0004, 1'b1, 32'h0200, 2'd1, 1'b0, 32'h0,    2'd0, 4'd4},
        '{1'b0, 32'h0004, 1'b0, 32'h0,    2'd0, 1'b1, 32'h0200, 2'd1, 4'd4}, // R4 refresh
        '{1'b1, 32'h0004, 1'b0, 32'h0,    2'd0, 1'b0, 32'h0,    2'd0, 4'd5},
        '{1'b0, 32'h0004, 1'b0, 32'h0,    2'd0, 1'b0, 32'h0008, 2'd0, 4'd5}, // R5 invalidate
        '{1'b1, 32'h1004, 1'b1, 32'h0010, 2'd2, 1'b0, 32'h0,    2'd0, 4'd6},
        '{1'b1, 32'h1404, 1'b1, 32'h0020, 2'd2, 1'b0, 32'h0,    2'd0, 4'd6},
        '{1'b1, 32'h1804, 1'b1, 32'h0030, 2'd2, 1'b0, 32'h0,    2'd0, 4'd6},
        '{1'b1, 32'h1C04, 1'b1, 32'h0040, 2'd2, 1'b0, 32'h0,    2'd0, 4'd6},
        '{1'b0, 32'h1404, 1'b0, 32'h0,    2'd0, 1'b1, 32'h0020, 2'd2, 4'd7}, // R7 four in a set
        '{1'b1, 32'h1004, 1'b1, 32'h0011, 2'd2, 1'b0, 32'h0,    2'd0, 4'd6},
        '{1'b1, 32'h2004, 1'b1, 32'h0050, 2'd0, 1'b0, 32'h0,    2'd0, 4'd6},
        '{1'b0, 32'h1404, 1'b0, 32'h0,    2'd0, 1'b0, 32'h1408, 2'd0, 4'd6}, // R6 oldest evicted
        '{1'b0, 32'h1004, 1'b0, 32'h0,    2'd0, 1'b1, 32'h0011, 2'd2, 4'd6},
        '{1'b0, 32'h1804, 1'b0, 32'h0,    2'd0, 1'b1, 32'h0030, 2'd2, 4'd6},
        '{1'b0, 32'h1C04, 1'b0, 32'h0,    2'd0, 1'b1, 32'h0040, 2'd2, 4'd6},
        '{1'b0, 32'h2004, 1'b0, 32'h0,    2'd0, 1'b1, 32'h0050, 2'd0, 4'd6},
        '{1'b1, 32'h2404, 1'b0, 32'h0,    2'd0, 1'b0, 32'h0,    2'd0, 4'd5},
        '{1'b0, 32'h2404, 1'b0, 32'h0,    2'd0, 1'b0, 32'h2408, 2'd0, 4'd5}, // R5 no allocation
        '{1'b0, 32'h2004, 1'b0, 32'h0,    2'd0, 1'b1, 32'h0050, 2'd0, 4'd5}  // R5 others intact
    };

    task automatic look(input logic [31:0] pc);
        @(negedge clk);
        lk_pc = pc;
        #1;
    endtask

    task automatic resolve(input logic [31:0] pc, input logic tk,
                           input logic [31:0] tgt, input logic [1:0] kd);
        @(negedge clk);
        rs_valid = 1'b1; rs_pc = pc; rs_taken = tk; rs_target = tgt; rs_type = kd;
        @(posedge clk);
        #1 rs_valid = 1'b0;
    endtask

    task automatic expect_lk(input string req, input logic eh,
                             input logic [31:0] et, input logic [1:0] ek);
        checks++;
        if (lk_hit !== eh || lk_target !== et || lk_type !== ek) begin
            errors++;
            $display("FAIL %s pc=%h: hit=%0b target=%h type=%0d expected hit=%0b target=%h type=%0d",
                     req, lk_pc, lk_hit, lk_target, lk_type, eh, et, ek);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: empty after reset
        look(32'h0004); expect_lk("R1", 1'b0, 32'h0008, 2'd0);
        look(32'h2000); expect_lk("R1", 1'b0, 32'h2004, 2'd0);

        for (int i = 0; i < NV; i++) begin
            if (TBL[i].upd) begin
                resolve(TBL[i].pc, TBL[i].tk, TBL[i].tgt, TBL[i].kd);
            end else begin
                look(TBL[i].pc);
                expect_lk($sformatf("R%0d", TBL[i].req), TBL[i].eh, TBL[i].et, TBL[i].ek);
            end
        end

        // R8: indirect entry with empty path slot falls back to buffer destination
        resolve(32'h2000, 1'b1, 32'h5004, 2'd3);   // slot 0 <- 5004, path -> 01
        look(32'h2000); expect_lk("R8", 1'b1, 32'h5004, 2'd3);
        resolve(32'h2000, 1'b1, 32'h6000, 2'd3);   // slot 1 <- 6000, path -> 04
        look(32'h2000); expect_lk("R8", 1'b1, 32'h6000, 2'd3);
        // R9: shift zeros into the path until it is 0 again
        resolve(32'h3000, 1'b1, 32'h7000, 2'd3);   // path -> 10
        resolve(32'h3000, 1'b1, 32'h7000, 2'd3);   // path -> 40
        look(32'h2000); expect_lk("R9", 1'b1, 32'h6000, 2'd3);
        resolve(32'h3000, 1'b1, 32'h7000, 2'd3);   // slot 40 written, path -> 00
        look(32'h2000); expect_lk("R9", 1'b1, 32'h5004, 2'd3);
        // R9: a direct resolution leaves path and table alone
        resolve(32'h0008, 1'b1, 32'h0900, 2'd0);
        look(32'h0008); expect_lk("R2", 1'b1, 32'h0900, 2'd0);
        look(32'h2000); expect_lk("R9", 1'b1, 32'h5004, 2'd3);
        // R5: not-taken removes an indirect entry
        resolve(32'h3000, 1'b0, 32'h0, 2'd3);
        look(32'h3000); expect_lk("R5", 1'b0, 32'h3004, 2'd0);

        // R1: reset empties the buffer again
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1 rst_n = 1'b1;
        look(32'h2000); expect_lk("R1", 1'b0, 32'h2004, 2'd0);
        look(32'h0008); expect_lk("R1", 1'b0, 32'h000C, 2'd0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule